// File: doc/BRIEF.md
# Three-Class Interrupt Entry Controller

This block sits beside the fetch stage of a simple in-order processor and decides, every cycle, whether an interrupt is taken and which one. Requests arrive in three classes (machine check, critical, noncritical), each with a two-bit cause kind. The cause kind says whether the request is asynchronous, synchronous precise or synchronous imprecise. The block owns the machine-state register. It keeps an independent save pair for each class: the saved return address, the saved machine state and a flag that tells which of two addresses a precise cause saved.

Arbitration is combinational. In the cycle a request wins, the block raises its grant bit and drives a redirect to the class's vector address. On the following clock edge it loads the class's save pair and clears the enable bits of that class and of every lower class. Requests are not latched: a request that loses stays asserted by its source until it is granted or withdrawn. A per-class return pulse reloads the machine state from that class's pair and redirects fetch to the saved address.

Class index is fixed everywhere: 0 = machine check, 1 = critical, 2 = noncritical. Packed buses place class c at `irq_kind[2c+1:2c]`, `save_pc[c*AW +: AW]` and `save_msr[c*MSR_W +: MSR_W]`. Machine-state enable bits are: bit 2 = machine-check enable, bit 1 = critical enable, bit 0 = external (noncritical) enable.

Top module: `irq_entry_ctrl`

## Requirements
- R1: At most one grant bit is high in any cycle, and the winner is the eligible request with the lowest class index (machine check over critical over noncritical), in the same cycle as the request.
- R2: A machine-check request is eligible only while machine-state bit 2 is set, for every cause kind.
- R3: An asynchronous critical request (kind 00) needs machine-state bit 1, and an asynchronous noncritical request needs bit 0. A critical or noncritical request with a synchronous kind (01, 10, 11) is eligible whatever those bits hold.
- R4: In a grant cycle, `redirect_valid` is 1 and `redirect_pc` equals the winning class's vector parameter.
- R5: For kind 00 (asynchronous), the saved address is `next_pc`.
- R6: For kind 01 (precise, at the faulting instruction), the saved address is `fault_pc` and the class's `save_after` bit becomes 0. For kind 10 (precise, after it), the saved address is `fault_pc` + `INSN_BYTES` and `save_after` becomes 1.
- R7: For kind 11 (imprecise), the saved address is `last_pc`, the last instruction that started execution.
- R8: On the edge after a grant, the class's saved state equals the machine state before the grant. The machine state loses the enable bits of that class and of all lower classes, and every other bit keeps its value.
- R9: A return pulse for a class sets the machine state to that class's saved state on the next edge and, in the same cycle, redirects to that class's saved address. The other classes' save pairs are left untouched.
- R10: A request that is masked or loses arbitration is not remembered. It is granted only when it is still asserted in a cycle in which it is eligible and wins.
- R11: Precedence within a cycle is grant over return over machine-state write. Among simultaneous return pulses the lowest class index is served.
- R12: After reset the machine state equals `MSR_RESET` (default 0, all classes masked), no grant or redirect is active, and every save pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 3 | Request per class, held by the source until granted or withdrawn |
| irq_kind | input | 6 | Two-bit cause kind per class: 00 async, 01 precise-at, 10 precise-after, 11 imprecise |
| next_pc | input | AW | Address of the instruction that would execute next |
| fault_pc | input | AW | Address of the instruction that raised a synchronous cause |
| last_pc | input | AW | Address of the last instruction that started execution |
| ret_cmd | input | 3 | Return pulse per class |
| msr_we | input | 1 | Machine-state write enable from the pipeline |
| msr_wdata | input | MSR_W | Machine-state write value |
| grant | output | 3 | One-hot grant of the winning class |
| redirect_valid | output | 1 | Fetch redirect request this cycle |
| redirect_pc | output | AW | Fetch redirect target |
| msr | output | MSR_W | Current machine state |
| save_pc | output | 3*AW | Saved return address per class |
| save_msr | output | 3*MSR_W | Saved machine state per class |
| save_after | output | 3 | Per class: 1 if a precise cause saved the following address |

## Verification
The arbiter is driven with all three classes requesting together and with the winner withdrawn one at a time, so fixed priority is distinguished from a request that is remembered after it has been masked. Each cause kind is applied with `next_pc`, `fault_pc` and `last_pc` set to distinct values, so every address source can be told apart in the saved address. Synchronous and asynchronous requests are applied under cleared enable bits, which separates the machine-check mask from the bypass the other two classes allow. Returns are issued in the same cycle as a grant, as a second return and as a state write, which shows the in-cycle precedence.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NCLS = 3;

    typedef enum logic [1:0] {
        CLS_MC   = 2'd0,
        CLS_CRIT = 2'd1,
        CLS_NC   = 2'd2
    } irq_cls_e;

    typedef enum logic [1:0] {
        KIND_ASYNC      = 2'b00,
        KIND_PREC_AT    = 2'b01,
        KIND_PREC_AFTER = 2'b10,
        KIND_IMPREC     = 2'b11
    } irq_kind_e;

    // Classes whose synchronous causes ignore the class enable bit
    localparam logic [NCLS-1:0] SYNC_BYPASS = 3'b110;

    // Machine-state bit that enables class c
    function automatic int en_bit(input int c);
        return NCLS - 1 - c;
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NCLS-1:0] req,
    input  logic [NCLS-1:0] is_sync,
    input  logic [NCLS-1:0] class_en,
    output logic [NCLS-1:0] grant
);

    logic [NCLS-1:0] eligible;

    for (genvar c = 0; c < NCLS; c++) begin : g_elig
        if (SYNC_BYPASS[c]) begin : g_bypass
            assign eligible[c] = req[c] & (class_en[c] | is_sync[c]);
        end else begin : g_strict
            assign eligible[c] = req[c] & class_en[c];
        end
    end

    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int c = 0; c < NCLS; c++) begin
            if (eligible[c] && !found) begin
                grant[c] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_ret_addr.sv
module irq_ret_addr
    import irq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] next_pc,
    input  logic [AW-1:0] fault_pc,
    input  logic [AW-1:0] last_pc,
    output logic [AW-1:0] ret_pc,
    output logic          after
);

    always_comb begin
        after = 1'b0;
        unique case (irq_kind_e'(kind))
            KIND_ASYNC:      ret_pc = next_pc;
            KIND_PREC_AT:    ret_pc = fault_pc;
            KIND_PREC_AFTER: begin
                ret_pc = fault_pc + AW'(INSN_BYTES);
                after  = 1'b1;
            end
            default:         ret_pc = last_pc;
        endcase
    end

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank #(
    parameter int AW    = 32,
    parameter int MSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    load_pc,
    input  logic [MSR_W-1:0] load_msr,
    input  logic             load_after,
    output logic [AW-1:0]    pc,
    output logic [MSR_W-1:0] msr,
    output logic             after
);

    typedef struct packed {
        logic [AW-1:0]    pc;
        logic [MSR_W-1:0] msr;
        logic             after;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (load) begin
            bank_d.pc    = load_pc;
            bank_d.msr   = load_msr;
            bank_d.after = load_after;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign pc    = bank_q.pc;
    assign msr   = bank_q.msr;
    assign after = bank_q.after;

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
#(
    parameter int                AW         = 32,
    parameter int                MSR_W      = 8,
    parameter int                INSN_BYTES = 4,
    parameter logic [AW-1:0]     VEC_MC     = 32'h0000_0200,
    parameter logic [AW-1:0]     VEC_CRIT   = 32'h0000_0100,
    parameter logic [AW-1:0]     VEC_NC     = 32'h0000_0500,
    parameter logic [MSR_W-1:0]  MSR_RESET  = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCLS-1:0]         irq_req,
    input  logic [2*NCLS-1:0]       irq_kind,
    input  logic [AW-1:0]           next_pc,
    input  logic [AW-1:0]           fault_pc,
    input  logic [AW-1:0]           last_pc,
    input  logic [NCLS-1:0]         ret_cmd,
    input  logic                    msr_we,
    input  logic [MSR_W-1:0]        msr_wdata,
    output logic [NCLS-1:0]         grant,
    output logic                    redirect_valid,
    output logic [AW-1:0]           redirect_pc,
    output logic [MSR_W-1:0]        msr,
    output logic [NCLS*AW-1:0]      save_pc,
    output logic [NCLS*MSR_W-1:0]   save_msr,
    output logic [NCLS-1:0]         save_after
);

    localparam int EN_W = NCLS;

    typedef struct packed {
        logic [MSR_W-1:0] msr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NCLS-1:0]  is_sync;
    logic [NCLS-1:0]  class_en;
    logic [AW-1:0]    cause_pc  [NCLS];
    logic             cause_aft [NCLS];
    logic [AW-1:0]    bank_pc   [NCLS];
    logic [MSR_W-1:0] bank_msr  [NCLS];

    function automatic logic [AW-1:0] vec_of(input int c);
        case (c)
            0:       return VEC_MC;
            1:       return VEC_CRIT;
            default: return VEC_NC;
        endcase
    endfunction

    // Enable bits of class c and every lower class
    function automatic logic [MSR_W-1:0] clear_mask(input int c);
        logic [MSR_W-1:0] m;
        m = '0;
        for (int b = 0; b < EN_W; b++) begin
            if (b <= en_bit(c)) m[b] = 1'b1;
        end
        return m;
    endfunction

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign is_sync[c]  = (irq_kind[2*c +: 2] != KIND_ASYNC);
        assign class_en[c] = ctl_q.msr[en_bit(c)];

        irq_ret_addr #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_addr (
            .kind     (irq_kind[2*c +: 2]),
            .next_pc  (next_pc),
            .fault_pc (fault_pc),
            .last_pc  (last_pc),
            .ret_pc   (cause_pc[c]),
            .after    (cause_aft[c])
        );

        irq_save_bank #(.AW(AW), .MSR_W(MSR_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (grant[c]),
            .load_pc    (cause_pc[c]),
            .load_msr   (ctl_q.msr),
            .load_after (cause_aft[c]),
            .pc         (bank_pc[c]),
            .msr        (bank_msr[c]),
            .after      (save_after[c])
        );

        assign save_pc[c*AW +: AW]        = bank_pc[c];
        assign save_msr[c*MSR_W +: MSR_W] = bank_msr[c];
    end

    irq_arbiter u_arb (
        .req      (irq_req),
        .is_sync  (is_sync),
        .class_en (class_en),
        .grant    (grant)
    );

    always_comb begin
        logic served;
        ctl_d          = ctl_q;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        served         = 1'b0;
        if (|grant) begin
            for (int c = 0; c < NCLS; c++) begin
                if (grant[c]) begin
                    ctl_d.msr      = ctl_q.msr & ~clear_mask(c);
                    redirect_valid = 1'b1;
                    redirect_pc    = vec_of(c);
                end
            end
        end else if (|ret_cmd) begin
            for (int c = 0; c < NCLS; c++) begin
                if (ret_cmd[c] && !served) begin
                    ctl_d.msr      = bank_msr[c];
                    redirect_valid = 1'b1;
                    redirect_pc    = bank_pc[c];
                    served         = 1'b1;
                end
            end
        end else if (msr_we) begin
            ctl_d.msr = msr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{msr: MSR_RESET};
        else        ctl_q <= ctl_d;
    end

    assign msr = ctl_q.msr;

    // R1: never two classes granted together
    a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: machine check only under its enable, any kind
    a_r2_mc_masked: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> msr[en_bit(0)]);

    // R3: async noncritical needs the external enable
    a_r3_async_nc_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[2] && irq_kind[5:4] == KIND_ASYNC) |-> msr[en_bit(2)]);

    // R8: machine check entry leaves all three enables cleared
    a_r8_mc_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |=> (msr[EN_W-1:0] == '0));

    // R8: critical entry saves the prior machine state
    a_r8_crit_saves_state: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |=> (save_msr[MSR_W +: MSR_W] == $past(msr)));

    // R9: sole noncritical return restores from its own pair
    a_r9_nc_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cmd == 3'b100 && grant == '0) |=> (msr == $past(save_msr[2*MSR_W +: MSR_W])));

endmodule

// File: tb/irq_entry_ctrl_test.sv
`timescale 1ns/1ps
module irq_entry_ctrl_test;

    localparam logic [31:0] V_MC = 32'h0000_0200;
    localparam logic [31:0] V_CR = 32'h0000_0100;
    localparam logic [31:0] V_NC = 32'h0000_0500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_req = '0;
    logic [5:0]  irq_kind = '0;
    logic [31:0] next_pc = '0, fault_pc = '0, last_pc = '0;
    logic [2:0]  ret_cmd = '0;
    logic        msr_we = 1'b0;
    logic [7:0]  msr_wdata = '0;
    logic [2:0]  grant;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [7:0]  msr;
    logic [95:0] save_pc;
    logic [23:0] save_msr;
    logic [2:0]  save_after;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_kind(irq_kind),
        .next_pc(next_pc), .fault_pc(fault_pc), .last_pc(last_pc),
        .ret_cmd(ret_cmd), .msr_we(msr_we), .msr_wdata(msr_wdata),
        .grant(grant), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .msr(msr), .save_pc(save_pc), .save_msr(save_msr), .save_after(save_after)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        irq_req = '0; irq_kind = '0; ret_cmd = '0; msr_we = 1'b0;
    endtask

    task automatic write_msr(input logic [7:0] v);
        msr_we = 1'b1; msr_wdata = v;
        cyc();
        msr_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 msr", msr, 8'h00);
        chk("R12 grant", grant, 3'b000);
        chk("R12 redirect", redirect_valid, 1'b0);
        chk("R12 save_pc", save_pc, '0);
        chk("R12 save_msr", save_msr, '0);
    endtask

    task automatic t_masked();
        // R2: sync machine check still masked with ME clear
        irq_req = 3'b001; irq_kind = 6'b00_00_01; #1;
        chk("R2 mc sync masked", grant, 3'b000);
        // R3: sync imprecise critical passes while mc masked
        next_pc = 32'h2008; fault_pc = 32'h2004; last_pc = 32'h2000;
        irq_req = 3'b011; irq_kind = 6'b00_11_01; #1;
        chk("R3 crit sync bypass", grant, 3'b010);
        chk("R4 crit vector", redirect_pc, V_CR);
        cyc(); idle();
        chk("R7 imprecise saves last_pc", save_pc[63:32], 32'h2000);
        chk("R8 crit saved state", save_msr[15:8], 8'h00);
        // R3: async noncritical masked by bit 0
        irq_req = 3'b100; #1;
        chk("R3 nc async masked", grant, 3'b000);
        idle();
    endtask

    task automatic t_priority();
        write_msr(8'hA7);
        chk("R8 msr written", msr, 8'hA7);
        next_pc = 32'h3000; fault_pc = 32'h2FFC; last_pc = 32'h2FF8;
        irq_req = 3'b111; irq_kind = '0; #1;
        chk("R1 mc wins", grant, 3'b001);
        chk("R4 mc vector", redirect_pc, V_MC);
        cyc();
        chk("R8 mc clears enables", msr, 8'hA0);
        chk("R5 async saves next_pc", save_pc[31:0], 32'h3000);
        chk("R8 mc saved state", save_msr[7:0], 8'hA7);
        irq_req = 3'b110; ret_cmd = 3'b001; #1;
        chk("R10 masked losers not granted", grant, 3'b000);
        chk("R9 mc return target", redirect_pc, 32'h3000);
        cyc(); ret_cmd = '0;
        chk("R9 mc restore", msr, 8'hA7);
        next_pc = 32'h3100; #1;
        chk("R10 pending crit taken", grant, 3'b010);
        cyc();
        chk("R8 crit clears", msr, 8'hA4);
        chk("R5 crit saved pc", save_pc[63:32], 32'h3100);
        irq_req = 3'b100; ret_cmd = 3'b010; #1;
        chk("R10 nc still masked", grant, 3'b000);
        cyc(); ret_cmd = '0;
        chk("R9 crit restore", msr, 8'hA7);
        next_pc = 32'h3200; #1;
        chk("R1 nc granted last", grant, 3'b100);
        chk("R4 nc vector", redirect_pc, V_NC);
        cyc(); irq_req = '0;
        chk("R8 nc clears", msr, 8'hA6);
        ret_cmd = 3'b100; cyc(); ret_cmd = '0;
        chk("R9 nc restore", msr, 8'hA7);
        chk("R9 crit pair untouched", save_pc[63:32], 32'h3100);
        chk("R9 mc pair untouched", save_pc[31:0], 32'h3000);
    endtask

    task automatic t_precise();
        fault_pc = 32'h4000; next_pc = 32'h4040; last_pc = 32'h3FF0;
        irq_req = 3'b100; irq_kind = 6'b01_00_00; #1;
        chk("R6 precise-at granted", grant, 3'b100);
        cyc(); idle();
        chk("R6 precise-at pc", save_pc[95:64], 32'h4000);
        chk("R6 precise-at flag", save_after[2], 1'b0);
        ret_cmd = 3'b100; cyc(); ret_cmd = '0;
        write_msr(8'hA6);
        irq_req = 3'b100; irq_kind = 6'b10_00_00; #1;
        chk("R3 nc sync bypass", grant, 3'b100);
        cyc(); idle();
        chk("R6 precise-after pc", save_pc[95:64], 32'h4004);
        chk("R6 precise-after flag", save_after[2], 1'b1);
        chk("R8 other bits kept", msr, 8'hA6);
        ret_cmd = 3'b100; cyc(); ret_cmd = '0;
    endtask

    task automatic t_collide();
        write_msr(8'hA7);
        next_pc = 32'h5000;
        irq_req = 3'b100; irq_kind = '0; ret_cmd = 3'b010; #1;
        chk("R11 grant beats return", redirect_pc, V_NC);
        cyc(); idle();
        chk("R11 return ignored", msr, 8'hA6);
        ret_cmd = 3'b101; #1;
        chk("R11 lowest return served", redirect_pc, 32'h3000);
        cyc(); ret_cmd = '0;
        chk("R11 mc state restored", msr, 8'hA7);
        ret_cmd = 3'b100; msr_we = 1'b1; msr_wdata = 8'h55;
        cyc(); idle();
        chk("R11 return beats write", msr, 8'hA7);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_masked();
        t_priority();
        t_precise();
        t_collide();
        done = 1;
        report();
    end

endmodule